// File: doc/BRIEF.md
# Packed SIMD Lane-Wise Integer Multiplier

This block multiplies two packed integer vectors lane by lane. A 2-bit size code chosen per operation cuts both operands into equal lanes of 8, 16 or 32 bits. Each pair of matching lanes is multiplied as unsigned numbers, and only the low lane-width bits of each product are kept. A width-select bit limits the operation to the low 64 bits of the vector or extends it to all 128 bits. In the 64-bit case the upper half of the result is forced to zero.

An operation begins with a one-cycle start strobe, which captures the operands and the controls. Exactly two clock cycles later, one of two outputs pulses. A legal operation raises the done strobe and presents the new result. An illegal encoding raises the undefined flag instead, and the result is left untouched. The delay does not depend on the operand values. A new operation may start on every cycle.

The datapath has one 32-bit multiplier unit for each 32-bit slice of the vector. Each unit is split into halves or bytes for the narrower lane sizes, so one set of units serves every arrangement.

Top module: `simd_lane_mul`

## Requirements
- R1: `size_i` selects the lane width. Code 0 gives 8-bit lanes, code 1 gives 16-bit lanes and code 2 gives 32-bit lanes.
- R2: With `full_i`=1 all 128 bits are processed. With `full_i`=0 only bits 63:0 are processed, and `result_o[127:64]` is 0 whatever the operands hold.
- R3: Each result lane equals the unsigned product of the matching operand lanes, truncated to the lane width. There is no saturation and no carry into a neighbouring lane. For example, all-ones operands give the value 1 in every lane.
- R4: Lane e of the result occupies bits [e*W+W-1 : e*W], where W is the lane width, and is computed from lane e of both operands. Lane 0 sits at the least significant bits.
- R5: Size code 3 is reserved, for either value of `full_i`. It raises `undef_o`, does not raise `done_o`, and leaves `result_o` unchanged.
- R6: `variant_i`=1 with a size code other than 0 raises `undef_o`, does not raise `done_o`, and leaves `result_o` unchanged. `variant_i`=1 with size code 0 is a normal 8-bit multiply.
- R7: `done_o` or `undef_o` pulses exactly two clock cycles after the cycle in which `start_i` is sampled high, whatever the operand data. Starts on back-to-back cycles give back-to-back results in order.
- R8: After reset, `done_o` and `undef_o` are 0 and `result_o` is all zeros.
- R9: `done_o` and `undef_o` are never high in the same cycle, and neither is high unless a start was sampled two cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Strobe that begins an operation |
| size_i | input | 2 | Lane width code (0: 8, 1: 16, 2: 32, 3: reserved) |
| full_i | input | 1 | 1: process 128 bits, 0: process the low 64 bits |
| variant_i | input | 1 | Operation variant; legal only with size code 0 |
| opa_i | input | 128 | First packed operand |
| opb_i | input | 128 | Second packed operand |
| result_o | output | 128 | Packed result, lane 0 at the least significant bits |
| done_o | output | 1 | One-cycle pulse when a legal result is ready |
| undef_o | output | 1 | One-cycle pulse when an illegal encoding was started |

## Verification
The bench builds the block with its default parameters: a 128-bit vector made of four 32-bit multiplier units. This covers all six legal lane arrangements, including the full-width ones, where the byte and half-word sub-products of every unit are exercised at once. It also covers the half-width case, where the two upper units must be masked. The stimulus includes all-ones operands, both reserved size-code cases, the illegal variant case, and starts on consecutive cycles. These show truncation, lane isolation, result retention after a rejected operation, and the fixed two-cycle timing.

// File: rtl/simd_mul_pkg.sv
package simd_mul_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } elem_sz_e;

endpackage

// File: rtl/simd_mul_decode.sv
module simd_mul_decode
  import simd_mul_pkg::*;
(
  input  logic [1:0] size_i,
  input  logic       variant_i,
  output logic       legal_o
);

  elem_sz_e sz;

  always_comb begin
    sz      = elem_sz_e'(size_i);
    legal_o = 1'b1;
    if (sz == SZ_RSVD) begin
      legal_o = 1'b0;
    end
    if (variant_i && (sz != SZ_BYTE)) begin
      legal_o = 1'b0;
    end
  end

endmodule

// File: rtl/simd_mul_unit.sv
module simd_mul_unit
  import simd_mul_pkg::*;
#(
  parameter int UNIT_W = 32
) (
  input  logic [UNIT_W-1:0] a_i,
  input  logic [UNIT_W-1:0] b_i,
  input  logic [1:0]        size_i,
  output logic [UNIT_W-1:0] p_o
);

  localparam int BYTE_W  = UNIT_W / 4;
  localparam int HALF_W  = UNIT_W / 2;
  localparam int N_BYTES = UNIT_W / BYTE_W;
  localparam int N_HALVES = UNIT_W / HALF_W;

  logic [UNIT_W-1:0] p_byte;
  logic [UNIT_W-1:0] p_half;
  logic [UNIT_W-1:0] p_word;

  // Sub-products keep only their own low bits, so nothing crosses a lane edge.
  for (genvar gb = 0; gb < N_BYTES; gb++) begin : g_byte
    assign p_byte[gb*BYTE_W +: BYTE_W] = a_i[gb*BYTE_W +: BYTE_W] * b_i[gb*BYTE_W +: BYTE_W];
  end

  for (genvar gh = 0; gh < N_HALVES; gh++) begin : g_half
    assign p_half[gh*HALF_W +: HALF_W] = a_i[gh*HALF_W +: HALF_W] * b_i[gh*HALF_W +: HALF_W];
  end

  assign p_word = a_i * b_i;

  always_comb begin
    case (elem_sz_e'(size_i))
      SZ_BYTE: p_o = p_byte;
      SZ_HALF: p_o = p_half;
      SZ_WORD: p_o = p_word;
      default: p_o = '0;
    endcase
  end

endmodule

// File: rtl/simd_lane_mul.sv
module simd_lane_mul
  import simd_mul_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int UNIT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        size_i,
  input  logic              full_i,
  input  logic              variant_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] result_o,
  output logic              done_o,
  output logic              undef_o
);

  localparam int N_UNITS    = DATA_W / UNIT_W;
  localparam int HALF_UNITS = N_UNITS / 2;

  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  // Decode of the requested encoding.
  logic legal;

  simd_mul_decode u_decode (
    .size_i    (size_i),
    .variant_i (variant_i),
    .legal_o   (legal)
  );

  // Stage 1: operand capture.
  logic [DATA_W-1:0] a_q, a_d, b_q, b_d;
  logic [1:0]        size_q, size_d;
  logic              full_q, full_d;
  logic              legal_q, legal_d;
  logic              vld_q, vld_d;

  always_comb begin
    a_d     = a_q;
    b_d     = b_q;
    size_d  = size_q;
    full_d  = full_q;
    legal_d = legal_q;
    vld_d   = start_i;
    if (start_i) begin
      a_d     = opa_i;
      b_d     = opb_i;
      size_d  = size_i;
      full_d  = full_i;
      legal_d = legal;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      a_q     <= '0;
      b_q     <= '0;
      size_q  <= '0;
      full_q  <= 1'b0;
      legal_q <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      a_q     <= a_d;
      b_q     <= b_d;
      size_q  <= size_d;
      full_q  <= full_d;
      legal_q <= legal_d;
      vld_q   <= vld_d;
    end
  end

  // Multiplier units, one per 32-bit slice; upper units masked in half mode.
  logic [DATA_W-1:0] prod;

  for (genvar gu = 0; gu < N_UNITS; gu++) begin : g_unit
    logic [UNIT_W-1:0] p;

    simd_mul_unit #(.UNIT_W(UNIT_W)) u_unit (
      .a_i    (a_q[gu*UNIT_W +: UNIT_W]),
      .b_i    (b_q[gu*UNIT_W +: UNIT_W]),
      .size_i (size_q),
      .p_o    (p)
    );

    if (gu < HALF_UNITS) begin : g_low
      assign prod[gu*UNIT_W +: UNIT_W] = p;
    end else begin : g_high
      assign prod[gu*UNIT_W +: UNIT_W] = full_q ? p : '0;
    end
  end

  // Stage 2: result and status.
  logic [DATA_W-1:0] res_q, res_d;
  logic              done_q, done_d;
  logic              undef_q, undef_d;
  logic              res_en;

  assign res_en = vld_q && legal_q;

  always_comb begin
    res_d   = res_en ? prod : res_q;
    done_d  = res_en;
    undef_d = vld_q && !legal_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q   <= '0;
      done_q  <= 1'b0;
      undef_q <= 1'b0;
    end else begin
      res_q   <= res_d;
      done_q  <= done_d;
      undef_q <= undef_d;
    end
  end

  assign result_o = res_q;
  assign done_o   = done_q;
  assign undef_o  = undef_q;

endmodule

// File: rtl/simd_lane_mul_chk.sv
module simd_lane_mul_chk #(
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [1:0]        size_i,
  input logic              full_i,
  input logic              variant_i,
  input logic [DATA_W-1:0] result_o,
  input logic              done_o,
  input logic              undef_o
);

  localparam int HALF = DATA_W / 2;

  // R9
  flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && undef_o));

  // R9
  done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(start_i, 2));

  // R5
  rsvd_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_i, 2) && ($past(size_i, 2) == 2'd3)) |-> (undef_o && !done_o));

  // R6
  bad_variant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_i, 2) && $past(variant_i, 2) && ($past(size_i, 2) != 2'd0)) |-> (undef_o && !done_o));

  // R7
  fixed_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(start_i, 2) && ($past(size_i, 2) != 2'd3) &&
     !($past(variant_i, 2) && ($past(size_i, 2) != 2'd0))) |-> done_o);

  // R2
  half_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !$past(full_i, 2)) |-> (result_o[DATA_W-1:HALF] == '0));

  // R5
  undef_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_o |-> $stable(result_o));

endmodule

bind simd_lane_mul simd_lane_mul_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .start_i   (start_i),
  .size_i    (size_i),
  .full_i    (full_i),
  .variant_i (variant_i),
  .result_o  (result_o),
  .done_o    (done_o),
  .undef_o   (undef_o)
);

// File: tb/test_simd_lane_mul.sv
`timescale 1ns/1ps
module test_simd_lane_mul;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start_i;
  logic [1:0]   size_i;
  logic         full_i;
  logic         variant_i;
  logic [127:0] opa_i, opb_i;
  logic [127:0] result_o;
  logic         done_o, undef_o;

  int total = 0;
  int bad   = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  simd_lane_mul i_simd_lane_mul (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i),
    .full_i(full_i), .variant_i(variant_i), .opa_i(opa_i), .opb_i(opb_i),
    .result_o(result_o), .done_o(done_o), .undef_o(undef_o)
  );

  localparam logic [127:0] PA = 128'hfedcba98_76543210_0f1e2d3c_4b5a6978;
  localparam logic [127:0] PB = 128'h13579bdf_2468ace0_80407020_ff01fe02;
  localparam logic [127:0] PC = 128'h00ff7f80_fffe0102_deadbeef_c0ffee11;
  localparam logic [127:0] ONES = {128{1'b1}};

  // {size, full, variant, exp_undef, a, b}
  localparam int NV = 11;
  localparam logic [260:0] TBL [NV] = '{
    {2'd0, 1'b1, 1'b0, 1'b0, PA, PB},
    {2'd0, 1'b0, 1'b0, 1'b0, PB, PC},
    {2'd1, 1'b1, 1'b0, 1'b0, PA, PC},
    {2'd1, 1'b0, 1'b0, 1'b0, PC, PB},
    {2'd2, 1'b1, 1'b0, 1'b0, PB, PA},
    {2'd2, 1'b0, 1'b0, 1'b0, PA, PA},
    {2'd0, 1'b1, 1'b1, 1'b0, PC, PA},
    {2'd2, 1'b1, 1'b0, 1'b0, ONES, ONES},
    {2'd3, 1'b0, 1'b0, 1'b1, PA, PB},
    {2'd3, 1'b1, 1'b0, 1'b1, PB, PC},
    {2'd1, 1'b1, 1'b1, 1'b1, PC, PC}
  };

  function automatic logic [127:0] ref_mul(input logic [127:0] a, input logic [127:0] b,
                                           input logic [1:0] sz, input logic full);
    int           esz;
    int           n;
    logic [127:0] r;
    logic [127:0] sa, sb;
    logic [31:0]  m, ea, eb;
    logic [63:0]  pr;
    esz = 8 << sz;
    n   = (full ? 128 : 64) / esz;
    r   = '0;
    m   = (esz == 32) ? 32'hffffffff : ((32'd1 << esz) - 32'd1);
    for (int e = 0; e < n; e++) begin
      sa = a >> (e * esz);
      sb = b >> (e * esz);
      ea = sa[31:0] & m;
      eb = sb[31:0] & m;
      pr = {32'd0, ea} * {32'd0, eb};
      r  = r | (({64'd0, pr} & {96'd0, m}) << (e * esz));
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] sz, input logic fl, input logic vr,
                       input logic [127:0] a, input logic [127:0] b);
    start_i = 1'b1; size_i = sz; full_i = fl; variant_i = vr; opa_i = a; opb_i = b;
  endtask

  initial begin
    rst_n = 1'b0; start_i = 1'b0; size_i = '0; full_i = 1'b0; variant_i = 1'b0;
    opa_i = '0; opb_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 reset state
    check(result_o == '0, "R8 result", result_o, '0);
    check(done_o == 1'b0, "R8 done", {127'd0, done_o}, '0);
    check(undef_o == 1'b0, "R8 undef", {127'd0, undef_o}, '0);

    // Table walk: R1 R2 R3 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [127:0] prev, exp;
      logic         xu;
      prev = result_o;
      xu   = TBL[i][256];
      exp  = xu ? prev : ref_mul(TBL[i][255:128], TBL[i][127:0], TBL[i][260:259], TBL[i][258]);
      drive(TBL[i][260:259], TBL[i][258], TBL[i][257], TBL[i][255:128], TBL[i][127:0]);
      @(negedge clk);
      start_i = 1'b0;
      check(!done_o && !undef_o, "R7 early", {126'd0, done_o, undef_o}, '0);
      @(negedge clk);
      check(done_o == !xu, "R7 done", {127'd0, done_o}, {127'd0, !xu});
      check(undef_o == xu, "R5/R6 undef", {127'd0, undef_o}, {127'd0, xu});
      check(result_o == exp, xu ? "R5/R6 keep" : "R1/R2/R3 result", result_o, exp);
      @(negedge clk);
    end

    // R4 lane ordering: 16-bit lanes hold e+1, times 2
    drive(2'd1, 1'b1, 1'b0, 128'h0008_0007_0006_0005_0004_0003_0002_0001, {8{16'h0002}});
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    check(result_o == 128'h0010_000e_000c_000a_0008_0006_0004_0002, "R4 order",
          result_o, 128'h0010_000e_000c_000a_0008_0006_0004_0002);

    // R3 truncation on 8-bit all-ones
    drive(2'd0, 1'b1, 1'b0, ONES, ONES);
    @(negedge clk); start_i = 1'b0;
    @(negedge clk);
    check(result_o == {16{8'h01}}, "R3 ones8", result_o, {16{8'h01}});

    // R7 back-to-back
    drive(2'd2, 1'b1, 1'b0, PA, PB);
    @(negedge clk);
    drive(2'd0, 1'b0, 1'b0, PC, PA);
    @(negedge clk);
    start_i = 1'b0;
    check(done_o && result_o == ref_mul(PA, PB, 2'd2, 1'b1), "R7 b2b first",
          result_o, ref_mul(PA, PB, 2'd2, 1'b1));
    @(negedge clk);
    check(done_o && result_o == ref_mul(PC, PA, 2'd0, 1'b0), "R7 b2b second",
          result_o, ref_mul(PC, PA, 2'd0, 1'b0));
    @(negedge clk);
    check(!done_o && !undef_o, "R9 idle", {126'd0, done_o, undef_o}, '0);

    ended = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!ended) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule